// File: doc/BRIEF.md
# Multiple-Register Transfer Sequencer

This block carries out the four multi-register memory instructions of a compressed 16-bit instruction set: stack push, stack pop, block store with base increment and block load with base increment. Each instruction names any subset of the low registers 0 to 7. A push can also store the link register, and a pop can also load the program counter. Once the decoder has identified the instruction, it presents the operation, the eight-bit register list, the extra-register flag and the three-bit base index together with a one-cycle `start`. The sequencer then reads the pointer register, issues one 32-bit access per transfer on a request/acknowledge memory port, and moves data through a register-file port. It writes the updated pointer back last and signals completion with a one-cycle `done`.

A push works from the highest register to the lowest. Before each store it lowers the pointer by four, and the link register is always stored first, so it lands at the top of the pushed area. The other three operations work from the lowest register to the highest and raise the pointer by four after each access. A pop loads the program counter after every listed register and asks the pipeline to flush in the same cycle as `done`.

Top module: `multi_xfer_seq`

## Requirements
- R1: After reset, and whenever the block is idle, `busy`, `done`, `flush`, `mem_req` and `rf_we` are all 0.
- R2: Push is op code 0 and uses register 13 as its pointer. It stores register 14 first when `extra` is 1, and then the listed registers in descending order. Each store goes to the address 4 below the previous pointer value, and the store data is the register's value when the instruction starts.
- R3: Pop is op code 1 and uses register 13 as its pointer. It loads the listed registers in ascending order, starting at the pointer and rising by 4. When `extra` is 1 it then loads register 15 from the next word and raises `flush` in the cycle of `done`.
- R4: Block store is op code 2. It uses register `base_idx` as the base and stores the listed registers in ascending order to ascending word addresses that start at the base. A base register that is in the list is stored with its original value.
- R5: Block load is op code 3. It loads the listed registers in ascending order from ascending word addresses that start at the base. `extra` has no effect on either block operation.
- R6: After the last access the pointer register holds its start value minus, for push, or plus, for the other operations, 4 times the number of transfers. A single-cycle `done` follows this writeback.
- R7: When the list is empty and no extra register applies, `done` is high in the cycle after `start`. The block makes no memory access and no register write.
- R8: While `mem_ack` is low, `mem_req` stays high with the same address, and no register write takes place.
- R9: A `start` that arrives while `busy` is 1 is ignored.
- R10: When a block load has its base in the list, the register ends with the written-back base value, not the loaded word.
- R11: `flush` is raised only for a pop with `extra` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an instruction (accepted when idle) |
| op | input | 2 | 0 push, 1 pop, 2 block store, 3 block load |
| rlist | input | 8 | Register list, bit i selects register i |
| extra | input | 1 | Add link register (push) or program counter (pop) |
| base_idx | input | 3 | Base register for block operations |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| flush | output | 1 | Pipeline flush request, with done |
| rf_raddr | output | 4 | Register-file read index |
| rf_rdata | input | 32 | Register-file read data (combinational) |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 4 | Register-file write index |
| rf_wdata | output | 32 | Register-file write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 store, 0 load |
| mem_addr | output | 32 | Word address |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, valid with ack |
| mem_ack | input | 1 | Access completes this cycle |

## Verification
Two events can share a cycle in a block load whose base register is also in the list: a loaded word is written to the register-file port, and the base register is written back. The design gives them separate cycles, with the writeback last. The bench provokes the case by drawing random base indices that often fall inside random lists, and it also stores a list that contains its own base. It judges the outcome from the register file after `done`: the base must hold start plus four times the transfer count, and a stored base must appear in memory with its original value. Random acknowledge gaps and a long forced stall push the accesses away from the command cycle.

// File: rtl/mxs_pkg.sv
package mxs_pkg;
  typedef enum logic [1:0] {
    MX_PUSH  = 2'd0,
    MX_POP   = 2'd1,
    MX_STBLK = 2'd2,
    MX_LDBLK = 2'd3
  } mx_op_e;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_PTR  = 3'd1,
    S_XFER = 3'd2,
    S_WB   = 3'd3,
    S_DONE = 3'd4
  } mx_state_e;
endpackage

// File: rtl/mxs_pick.sv
// Priority picker over the remaining register mask.
module mxs_pick #(
  parameter int N          = 8,
  parameter bit HIGH_FIRST = 1'b0,
  localparam int IW        = $clog2(N)
) (
  input  logic [N-1:0]  mask,
  output logic          found,
  output logic [IW-1:0] idx
);
  generate
    if (HIGH_FIRST) begin : g_high
      always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
          if (mask[i]) begin
            found = 1'b1;
            idx   = IW'(i);
          end
        end
      end
    end else begin : g_low
      always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
          if (mask[i]) begin
            found = 1'b1;
            idx   = IW'(i);
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/mxs_ptr.sv
// Access address and next pointer for pre-decrement or post-increment walks.
module mxs_ptr #(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic [AW-1:0] ptr,
  input  logic          descend,
  output logic [AW-1:0] acc_addr,
  output logic [AW-1:0] ptr_next
);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  logic [AW-1:0] dec_v;
  logic [AW-1:0] inc_v;

  always_comb begin
    dec_v    = ptr - STEP_V;
    inc_v    = ptr + STEP_V;
    acc_addr = descend ? dec_v : ptr;
    ptr_next = descend ? dec_v : inc_v;
  end
endmodule

// File: rtl/multi_xfer_seq.sv
module multi_xfer_seq
  import mxs_pkg::*;
#(
  parameter int DW     = 32,
  parameter int AW     = 32,
  parameter int LIST_N = 8,
  parameter int RIW    = 4,
  parameter int BIW    = 3,
  parameter int SP_IDX = 13,
  parameter int LR_IDX = 14,
  parameter int PC_IDX = 15,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [LIST_N-1:0] rlist,
  input  logic              extra,
  input  logic [BIW-1:0]    base_idx,
  output logic              busy,
  output logic              done,
  output logic              flush,
  output logic [RIW-1:0]    rf_raddr,
  input  logic [DW-1:0]     rf_rdata,
  output logic              rf_we,
  output logic [RIW-1:0]    rf_waddr,
  output logic [DW-1:0]     rf_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              mem_ack
);
  localparam int LIW = $clog2(LIST_N);
  localparam logic [RIW-1:0] SP_R = RIW'(SP_IDX);
  localparam logic [RIW-1:0] LR_R = RIW'(LR_IDX);
  localparam logic [RIW-1:0] PC_R = RIW'(PC_IDX);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  // State
  mx_state_e         state_q, state_d;
  mx_op_e            op_q;
  logic [RIW-1:0]    pidx_q;
  logic              pcload_q;
  logic [LIST_N-1:0] mask_q, mask_d;
  logic              extra_q, extra_d;
  logic [AW-1:0]     ptr_q, ptr_d;

  // Datapath helpers
  logic              lo_found, hi_found;
  logic [LIW-1:0]    lo_idx, hi_idx;
  logic              descend, is_load, use_extra, more_after;
  logic [RIW-1:0]    cur_reg;
  logic [LIST_N-1:0] cur_clr, mask_after;
  logic              extra_after;
  logic [AW-1:0]     acc_addr, ptr_next;
  logic              cmd_en, list_en, ptr_en, xfer_ack;
  logic              extra_in, empty_in;

  mxs_pick #(.N(LIST_N), .HIGH_FIRST(1'b0)) u_pick_lo (
    .mask(mask_q), .found(lo_found), .idx(lo_idx)
  );
  mxs_pick #(.N(LIST_N), .HIGH_FIRST(1'b1)) u_pick_hi (
    .mask(mask_q), .found(hi_found), .idx(hi_idx)
  );
  mxs_ptr #(.AW(AW), .STEP(STEP)) u_ptr (
    .ptr(ptr_q), .descend(descend), .acc_addr(acc_addr), .ptr_next(ptr_next)
  );

  always_comb begin
    descend  = (op_q == MX_PUSH);
    is_load  = (op_q == MX_POP) || (op_q == MX_LDBLK);
    cmd_en   = (state_q == S_IDLE) && start;
    xfer_ack = (state_q == S_XFER) && mem_ack;
    extra_in = extra && ((op == 2'(MX_PUSH)) || (op == 2'(MX_POP)));
    empty_in = (rlist == '0) && !extra_in;

    // Push serves the extra register first, pop serves it last.
    if (descend) use_extra = extra_q;
    else         use_extra = extra_q && !lo_found;

    cur_clr = '0;
    if (use_extra) begin
      cur_reg = descend ? LR_R : PC_R;
    end else if (descend) begin
      cur_reg = RIW'(hi_idx);
      cur_clr[hi_idx] = hi_found;
    end else begin
      cur_reg = RIW'(lo_idx);
      cur_clr[lo_idx] = lo_found;
    end
    mask_after  = mask_q & ~cur_clr;
    extra_after = extra_q & ~use_extra;
    more_after  = (mask_after != '0) || extra_after;
  end

  // Next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (start) state_d = empty_in ? S_DONE : S_PTR;
      S_PTR:  state_d = S_XFER;
      S_XFER: if (mem_ack && !more_after) state_d = S_WB;
      S_WB:   state_d = S_DONE;
      S_DONE: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_comb begin
    list_en = cmd_en || xfer_ack;
    mask_d  = cmd_en ? rlist : mask_after;
    extra_d = cmd_en ? extra_in : extra_after;
    ptr_en  = (state_q == S_PTR) || xfer_ack;
    ptr_d   = (state_q == S_PTR) ? AW'(rf_rdata) : ptr_next;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q  <= S_IDLE;
      op_q     <= MX_PUSH;
      pidx_q   <= '0;
      pcload_q <= 1'b0;
      mask_q   <= '0;
      extra_q  <= 1'b0;
      ptr_q    <= '0;
    end else begin
      state_q <= state_d;
      if (cmd_en) begin
        op_q     <= mx_op_e'(op);
        pidx_q   <= (op[1] == 1'b0) ? SP_R : RIW'(base_idx);
        pcload_q <= (op == 2'(MX_POP)) && extra;
      end
      if (list_en) begin
        mask_q  <= mask_d;
        extra_q <= extra_d;
      end
      if (ptr_en) ptr_q <= ptr_d;
    end
  end

  // Outputs
  always_comb begin
    busy      = (state_q != S_IDLE);
    done      = (state_q == S_DONE);
    flush     = done && pcload_q;
    mem_req   = (state_q == S_XFER);
    mem_we    = !is_load;
    mem_addr  = acc_addr;
    mem_wdata = rf_rdata;
    rf_raddr  = (state_q == S_XFER) ? cur_reg : pidx_q;
    rf_we     = (xfer_ack && is_load) || (state_q == S_WB);
    rf_waddr  = (state_q == S_WB) ? pidx_q : cur_reg;
    rf_wdata  = (state_q == S_WB) ? DW'(ptr_q) : mem_rdata;
  end
endmodule

// File: rtl/mxs_chk.sv
module mxs_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          flush,
  input logic          rf_we,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr
);
  // R1: an idle block drives no memory request and no register write
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !rf_we));

  // R8: a pending request keeps its address and direction until ack
  a_r8_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R8: a stalled access produces no register write
  a_r8_no_write_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |-> !rf_we);

  // R6: done lasts a single cycle
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11: flush only accompanies done
  a_r11_flush_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> done);

  // R4: a register write never coincides with a store
  a_r4_no_write_on_store: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> !(mem_req && mem_we));
endmodule

bind multi_xfer_seq mxs_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .flush(flush),
  .rf_we(rf_we), .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr)
);

// File: tb/sim_multi_xfer_seq.sv
`timescale 1ns/1ps
module sim_multi_xfer_seq;
  logic        clk;
  logic        rst_n;
  logic        start;
  logic [1:0]  op;
  logic [7:0]  rlist;
  logic        extra;
  logic [2:0]  base_idx;
  logic        busy, done, flush;
  logic [3:0]  rf_raddr, rf_waddr;
  logic [31:0] rf_rdata, rf_wdata;
  logic        rf_we;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  logic [31:0] regs [16];
  logic [31:0] mem  [64];
  logic        ack_en;
  logic        stall;
  int          nlog, nrfw, cyc;
  logic [31:0] log_addr [20];
  logic [31:0] log_data [20];
  logic        log_we   [20];
  int          n_checks, n_fail;

  multi_xfer_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .rlist(rlist),
    .extra(extra), .base_idx(base_idx), .busy(busy), .done(done),
    .flush(flush), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  assign rf_rdata  = regs[rf_raddr];
  assign mem_rdata = mem[mem_addr[7:2]];
  assign mem_ack   = mem_req && ack_en && !stall;

  always @(negedge clk) ack_en <= ($urandom % 4) != 0;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (mem_req && mem_ack) begin
      if (nlog < 20) begin
        log_addr[nlog] = mem_addr;
        log_we[nlog]   = mem_we;
        log_data[nlog] = mem_we ? mem_wdata : mem[mem_addr[7:2]];
      end
      nlog = nlog + 1;
      if (mem_we) mem[mem_addr[7:2]] = mem_wdata;
    end
    if (rf_we) begin
      regs[rf_waddr] = rf_wdata;
      nrfw = nrfw + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #600000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", cyc, 0);
    finish_run();
  end

  // Run one instruction and compare against a model built from R2..R6, R10, R11.
  task automatic run_op(input logic [1:0] o, input logic [7:0] l, input logic x,
                        input logic [2:0] b, input logic [31:0] pinit,
                        input bit mid_start, input string tag);
    logic [31:0] sr [16];
    logic [31:0] sm [64];
    logic [31:0] ea [20];
    logic [31:0] ed [20];
    logic [3:0]  edst [20];
    int          ne, waited, bad;
    logic [3:0]  pidx;
    logic [31:0] p, fa, fe;
    bit          load, xe;
    @(negedge clk);
    for (int i = 0; i < 16; i++) regs[i] = $urandom;
    pidx = (o[1] == 1'b0) ? 4'd13 : {1'b0, b};
    regs[pidx] = pinit;
    for (int i = 0; i < 16; i++) sr[i] = regs[i];
    for (int i = 0; i < 64; i++) sm[i] = mem[i];
    load = (o == 2'd1) || (o == 2'd3);
    xe   = x && (o[1] == 1'b0);
    p = pinit;
    ne = 0;
    if (o == 2'd0) begin
      if (xe) begin p = p - 32'd4; ea[ne] = p; ed[ne] = sr[14]; edst[ne] = 4'd14; ne++; end
      for (int i = 7; i >= 0; i--)
        if (l[i]) begin p = p - 32'd4; ea[ne] = p; ed[ne] = sr[i]; edst[ne] = 4'(i); ne++; end
    end else begin
      for (int i = 0; i < 8; i++)
        if (l[i]) begin
          ea[ne] = p; ed[ne] = load ? sm[p[7:2]] : sr[i]; edst[ne] = 4'(i); ne++;
          p = p + 32'd4;
        end
      if (o == 2'd1 && xe) begin
        ea[ne] = p; ed[ne] = sm[p[7:2]]; edst[ne] = 4'd15; ne++; p = p + 32'd4;
      end
    end
    nlog = 0;
    nrfw = 0;
    op = o; rlist = l; extra = x; base_idx = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waited = 0;
    fa = 32'd0;
    while (!done && waited < 2000) begin
      if (mid_start && waited == 2) begin
        // R9: a second start while busy must be ignored
        op = ~o; rlist = ~l; extra = ~x; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      waited++;
    end
    start = 1'b0;
    fa = {31'd0, flush};
    check(done, {tag, " done reached"}, {31'd0, done}, 32'd1);
    @(negedge clk);
    check(nlog == ne, {tag, " access count"}, nlog, ne);
    bad = 0;
    for (int i = 0; i < ne && i < nlog; i++)
      if (log_addr[i] !== ea[i] || log_data[i] !== ed[i] || log_we[i] !== !load) bad++;
    check(bad == 0, {tag, " address/data order"}, bad, 0);
    check(regs[pidx] == p, {tag, " R6 final pointer"}, regs[pidx], p);
    if (load) begin
      bad = 0;
      for (int i = 0; i < ne; i++)
        if (edst[i] != pidx && regs[edst[i]] !== ed[i]) bad++;
      check(bad == 0, {tag, " loaded registers"}, bad, 0);
    end
    fe = {31'd0, (o == 2'd1) && x};
    check(fa == fe, {tag, " R11 flush"}, fa, fe);
  endtask

  initial begin
    n_checks = 0; n_fail = 0; nlog = 0; nrfw = 0; cyc = 0;
    void'($urandom(32'd1357));
    stall = 1'b0;
    start = 1'b0; op = 2'd0; rlist = 8'd0; extra = 1'b0; base_idx = 3'd0;
    for (int i = 0; i < 64; i++) mem[i] = $urandom;
    for (int i = 0; i < 16; i++) regs[i] = 32'd0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !flush && !mem_req && !rf_we, "R1 outputs in reset",
          {27'd0, busy, done, flush, mem_req, rf_we}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !done && !mem_req && !rf_we, "R1 idle after reset",
          {28'd0, busy, done, mem_req, rf_we}, 32'd0);

    // Directed cases
    run_op(2'd0, 8'b1010_0101, 1'b1, 3'd0, 32'h0000_00C0, 0, "R2 push with LR");
    run_op(2'd0, 8'b1000_0000, 1'b0, 3'd0, 32'h0000_00C0, 0, "R2 push single");
    run_op(2'd1, 8'b0110_0011, 1'b1, 3'd0, 32'h0000_0040, 0, "R3 pop with PC");
    run_op(2'd1, 8'b0000_0000, 1'b1, 3'd0, 32'h0000_0040, 0, "R3 pop only PC");
    run_op(2'd2, 8'b0001_1111, 1'b1, 3'd3, 32'h0000_0060, 0, "R4 store base in list");
    run_op(2'd3, 8'b1111_1111, 1'b1, 3'd2, 32'h0000_0020, 0, "R5 load all");
    run_op(2'd3, 8'b0001_0010, 1'b0, 3'd4, 32'h0000_0080, 0, "R10 load base in list");
    run_op(2'd0, 8'b0011_1100, 1'b0, 3'd0, 32'h0000_00C0, 1, "R9 start while busy");

    // R7: empty list
    @(negedge clk);
    regs[13] = 32'h0000_0090;
    nlog = 0; nrfw = 0;
    op = 2'd0; rlist = 8'd0; extra = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done, "R7 done one cycle after start", {31'd0, done}, 32'd1);
    @(negedge clk);
    check(nlog == 0 && nrfw == 0, "R7 no access or write", nlog + nrfw, 0);
    check(regs[13] == 32'h0000_0090, "R7 pointer unchanged", regs[13], 32'h90);
    op = 2'd2; rlist = 8'd0; extra = 1'b1; base_idx = 3'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done && !flush, "R7 block op ignores extra", {30'd0, done, flush}, 32'd2);
    @(negedge clk);

    // R8: forced stall
    regs[13] = 32'h0000_00A0;
    nlog = 0; nrfw = 0;
    stall = 1'b1;
    op = 2'd0; rlist = 8'b1000_0001; extra = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    check(mem_req && mem_addr == 32'h0000_009C && nlog == 0 && nrfw == 0,
          "R8 request held during stall", mem_addr, 32'h0000_009C);
    stall = 1'b0;
    while (!done && cyc < 100000) @(negedge clk);
    @(negedge clk);
    check(nlog == 3 && regs[13] == 32'h0000_0094, "R8 completes after stall",
          regs[13], 32'h0000_0094);

    // Random mix
    for (int k = 0; k < 40; k++) begin
      logic [1:0] ro;
      logic [31:0] pi;
      ro = 2'($urandom % 4);
      case (ro)
        2'd0: pi = 32'h0000_00C0;
        2'd1: pi = 32'h0000_0040;
        default: pi = 32'h0000_0060;
      endcase
      run_op(ro, 8'($urandom), 1'($urandom), 3'($urandom), pi, 0, "R6 random");
    end
    finish_run();
  end
endmodule